// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block draws a 64x64 two-plane pointer on top of a scanline pixel stream. Software programs a cursor position, a hotspot offset, a bitmap base address and two 24-bit colours through a small indexed register port. The display timing logic supplies a line number, a pixel column, the incoming 32-bit pixel, the visible screen width and the last visible line. The block returns the pixel with the cursor mixed in.

At the start of each line, signalled by a one-cycle `line_start` pulse during horizontal blanking, the block checks whether that line crosses the cursor. If it does, the block reads the 16 bitmap bytes for that cursor row through a byte-wide memory read port. The first eight bytes form the AND plane and the last eight form the XOR plane. Both planes are kept in line buffers, so the per-pixel mixing is pure combinational logic and makes no memory access.

New position, hotspot and base values are staged and become active only on a `frame_start` pulse. A lock bit can hold them off, so that a multi-register update never shows a half-written cursor. Colours take effect at once.

Top module: `cursor_overlay`

## Requirements
- R1: After reset every register reads as zero, `mem_rd_en` is low, and `pix_out` equals `pix_in`.
- R2: Register indices are 0 base, 1 position, 2 hotspot, 3 colour0 and 4 colour1. Each write is masked:
  - base: 0x87FFFFF0
  - position: 0x3FFF0FFF, with X in bits 29:16 and Y in bits 11:0
  - hotspot: 0x003F003F, with the horizontal offset in bits 21:16 and the vertical offset in bits 5:0
  - colours: 0x00FFFFFF
- R3: Bit 31 of the base register is the lock. A write to the position or hotspot register copies its bit 31 into the lock. Reads of the position and hotspot registers return the lock in bit 31.
- R4: Staged position, hotspot and base values move to the active set only on a `frame_start` pulse while the lock is clear. Before that pulse the old values keep being used.
- R5: A `line_start` pulse on a cursor line issues 16 reads, one per cycle, at consecutive byte addresses. The reads start at base − hx − 16·hy + 16·(line − Y). Read data is taken one cycle after each request.
- R6: Each cursor pixel is decoded from its AND bit and XOR bit:
  - AND=1, XOR=1: the bitwise inverse of `pix_in`
  - AND=1, XOR=0: `pix_in` unchanged
  - AND=0, XOR=1: {colour1, 8'hFF}
  - AND=0, XOR=0: {colour0, 8'hFF}
- R7: Cursor column c takes bit 7−(c mod 8) of AND byte c/8 and of XOR byte 8 + c/8 in the fetched row.
- R8: No pixel is altered, and no fetch is made, when the line is below Y, at or beyond Y+64, or beyond `vdisp`, or when `cur_en` is low at fetch time. A low `cur_en` also leaves every pixel unchanged.
- R9: Only pixels with X ≤ `pix_x` < X+64 and `pix_x` < `scr_width` are altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| frame_start | input | 1 | Frame boundary pulse |
| line_start | input | 1 | Line prefetch pulse, during horizontal blanking |
| line_y | input | 12 | Line number for the next visible line |
| vdisp | input | 12 | Last visible line number |
| cur_en | input | 1 | Cursor enable |
| pix_x | input | 14 | Current pixel column |
| pix_in | input | 32 | Underlying pixel |
| scr_width | input | 14 | Visible screen width in pixels |
| mem_rd_en | output | 1 | Bitmap byte read request |
| mem_rd_addr | output | AW | Bitmap byte address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| pix_out | output | 32 | Pixel with the cursor mixed in |

## Verification
If the line buffers are corrupted or the bit order is wrong, the wrong pixels come out on the very next line drawn. The sweeps across the cursor columns catch this in the same cycle as the bad pixel. If the fetch address or row index is wrong, the 16-read burst visible at the memory port is wrong within one line. A lock or frame-transfer fault shows up as a cursor drawn at the old or new column one frame too early or too late.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  localparam int CUR_DIM     = 64;
  localparam int ROW_BYTES   = 16;
  localparam int PLANE_BYTES = 8;
  localparam int XW          = 14;
  localparam int YW          = 12;
  localparam int HOTW        = 6;
  localparam int COLW        = 24;
  localparam int ADDR_W      = 27;

  localparam logic [31:0] MASK_BASE = 32'h87FF_FFF0;
  localparam logic [31:0] MASK_POS  = 32'h3FFF_0FFF;
  localparam logic [31:0] MASK_HOT  = 32'h003F_003F;
  localparam logic [31:0] MASK_COL  = 32'h00FF_FFFF;

  typedef enum logic [2:0] {
    RI_BASE = 3'd0,
    RI_POS  = 3'd1,
    RI_HOT  = 3'd2,
    RI_COL0 = 3'd3,
    RI_COL1 = 3'd4
  } reg_idx_e;

  typedef enum logic [1:0] {PX_COL0, PX_COL1, PX_KEEP, PX_INV} px_kind_e;

  function automatic px_kind_e classify(input logic and_b, input logic xor_b);
    case ({and_b, xor_b})
      2'b00:   return PX_COL0;
      2'b01:   return PX_COL1;
      2'b10:   return PX_KEEP;
      default: return PX_INV;
    endcase
  endfunction

  function automatic logic [31:0] apply_px(input px_kind_e k, input logic [31:0] under,
                                           input logic [COLW-1:0] c0,
                                           input logic [COLW-1:0] c1);
    case (k)
      PX_COL0: return {c0, 8'hFF};
      PX_COL1: return {c1, 8'hFF};
      PX_KEEP: return under;
      default: return ~under;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] bitmap_origin(input logic [ADDR_W-1:0] base,
                                                      input logic [HOTW-1:0] hx,
                                                      input logic [HOTW-1:0] hy);
    return base - ADDR_W'(hx) - (ADDR_W'(hy) << 4);
  endfunction
endpackage

// File: rtl/cursor_ovl_regs.sv
module cursor_ovl_regs
  import cursor_ovl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        idx,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              frame_start,
  output logic [XW-1:0]     act_x,
  output logic [YW-1:0]     act_y,
  output logic [ADDR_W-1:0] act_origin,
  output logic [COLW-1:0]   col0,
  output logic [COLW-1:0]   col1,
  output logic              locked,
  output logic              load_ev
);
  logic [31:0] base_q, pos_q, hot_q, col0_q, col1_q;

  assign locked  = base_q[31];
  assign load_ev = frame_start & ~base_q[31];
  assign col0    = col0_q[COLW-1:0];
  assign col1    = col1_q[COLW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pos_q  <= '0;
      hot_q  <= '0;
      col0_q <= '0;
      col1_q <= '0;
    end else if (wr_en) begin
      case (reg_idx_e'(idx))
        RI_BASE: base_q <= wdata & MASK_BASE;
        RI_POS: begin
          pos_q      <= wdata & MASK_POS;
          base_q[31] <= wdata[31];
        end
        RI_HOT: begin
          hot_q      <= wdata & MASK_HOT;
          base_q[31] <= wdata[31];
        end
        RI_COL0: col0_q <= wdata & MASK_COL;
        RI_COL1: col1_q <= wdata & MASK_COL;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_x      <= '0;
      act_y      <= '0;
      act_origin <= '0;
    end else if (load_ev) begin
      act_x      <= pos_q[16 +: XW];
      act_y      <= pos_q[YW-1:0];
      act_origin <= bitmap_origin(base_q[ADDR_W-1:0], hot_q[16 +: HOTW], hot_q[HOTW-1:0]);
    end
  end

  always_comb begin
    case (reg_idx_e'(idx))
      RI_BASE: rdata = base_q;
      RI_POS:  rdata = {base_q[31], pos_q[30:0]};
      RI_HOT:  rdata = {base_q[31], hot_q[30:0]};
      RI_COL0: rdata = col0_q;
      RI_COL1: rdata = col1_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cursor_ovl_fetch.sv
module cursor_ovl_fetch
  import cursor_ovl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  logic [YW-1:0]      line_y,
  input  logic [YW-1:0]      vdisp,
  input  logic [YW-1:0]      act_y,
  input  logic               cur_en,
  input  logic [ADDR_W-1:0]  origin,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [7:0]         rd_data,
  output logic [CUR_DIM-1:0] and_row,
  output logic [CUR_DIM-1:0] xor_row,
  output logic               line_hit,
  output logic               fetch_go
);
  localparam int CNT_W  = $clog2(ROW_BYTES);
  localparam int ROW_W  = $clog2(CUR_DIM);
  localparam int LANE_W = $clog2(PLANE_BYTES);

  logic [YW:0]         dy;
  logic                row_hit;
  logic                busy_q, hit_q, pend_q;
  logic [CNT_W-1:0]    cnt_q, pend_idx_q;
  logic [ADDR_W-1:0]   row_addr_q;

  assign dy       = {1'b0, line_y} - {1'b0, act_y};
  assign row_hit  = cur_en && (line_y >= act_y) && (dy < (YW+1)'(CUR_DIM)) && (line_y <= vdisp);
  assign fetch_go = line_start && !busy_q;
  assign rd_en    = busy_q;
  assign rd_addr  = row_addr_q + ADDR_W'(cnt_q);
  assign line_hit = hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      hit_q      <= 1'b0;
      cnt_q      <= '0;
      row_addr_q <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      pend_q     <= busy_q;
      pend_idx_q <= cnt_q;
      if (fetch_go) begin
        hit_q <= row_hit;
        if (row_hit) begin
          busy_q     <= 1'b1;
          cnt_q      <= '0;
          row_addr_q <= origin + (ADDR_W'(dy[ROW_W-1:0]) << CNT_W);
        end
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(ROW_BYTES - 1)) busy_q <= 1'b0;
      end
    end
  end

  for (genvar b = 0; b < PLANE_BYTES; b++) begin : g_lane
    logic [7:0] a_q, x_q;
    logic       sel;
    assign sel = pend_q && (pend_idx_q[LANE_W-1:0] == LANE_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        x_q <= '0;
      end else if (sel) begin
        if (!pend_idx_q[LANE_W]) a_q <= rd_data;
        else                     x_q <= rd_data;
      end
    end
    assign and_row[(PLANE_BYTES-1-b)*8 +: 8] = a_q;
    assign xor_row[(PLANE_BYTES-1-b)*8 +: 8] = x_q;
  end
endmodule

// File: rtl/cursor_ovl_mix.sv
module cursor_ovl_mix
  import cursor_ovl_pkg::*;
(
  input  logic [XW-1:0]      pix_x,
  input  logic [XW-1:0]      act_x,
  input  logic [XW-1:0]      scr_width,
  input  logic               line_hit,
  input  logic               cur_en,
  input  logic [CUR_DIM-1:0] and_row,
  input  logic [CUR_DIM-1:0] xor_row,
  input  logic [COLW-1:0]    c0,
  input  logic [COLW-1:0]    c1,
  input  logic [31:0]        pix_in,
  output logic [31:0]        pix_out,
  output logic               in_win
);
  localparam int ROW_W = $clog2(CUR_DIM);

  logic [XW-1:0]    dx;
  logic [ROW_W-1:0] sel;

  assign dx     = pix_x - act_x;
  assign in_win = cur_en && line_hit && (pix_x >= act_x) &&
                  (dx < XW'(CUR_DIM)) && (pix_x < scr_width);
  assign sel    = ROW_W'(CUR_DIM - 1) - dx[ROW_W-1:0];
  assign pix_out = in_win ? apply_px(classify(and_row[sel], xor_row[sel]), pix_in, c0, c1)
                          : pix_in;
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_idx,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic [11:0]   line_y,
  input  logic [11:0]   vdisp,
  input  logic          cur_en,
  input  logic [13:0]   pix_x,
  input  logic [31:0]   pix_in,
  input  logic [13:0]   scr_width,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic [31:0]   pix_out
);
  logic [XW-1:0]      act_x;
  logic [YW-1:0]      act_y;
  logic [ADDR_W-1:0]  act_origin, fetch_addr;
  logic [COLW-1:0]    col0, col1;
  logic               locked, load_ev, line_hit, fetch_go, in_win;
  logic [CUR_DIM-1:0] and_row, xor_row;

  cursor_ovl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .frame_start(frame_start), .act_x(act_x), .act_y(act_y),
    .act_origin(act_origin), .col0(col0), .col1(col1), .locked(locked), .load_ev(load_ev)
  );

  cursor_ovl_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_y(line_y), .vdisp(vdisp),
    .act_y(act_y), .cur_en(cur_en), .origin(act_origin), .rd_en(mem_rd_en),
    .rd_addr(fetch_addr), .rd_data(mem_rd_data), .and_row(and_row), .xor_row(xor_row),
    .line_hit(line_hit), .fetch_go(fetch_go)
  );

  assign mem_rd_addr = AW'(fetch_addr);

  cursor_ovl_mix u_mix (
    .pix_x(pix_x), .act_x(act_x), .scr_width(scr_width), .line_hit(line_hit),
    .cur_en(cur_en), .and_row(and_row), .xor_row(xor_row), .c0(col0), .c1(col1),
    .pix_in(pix_in), .pix_out(pix_out), .in_win(in_win)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_ovl_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cur_en,
  input logic [13:0]   pix_x,
  input logic [13:0]   scr_width,
  input logic [31:0]   pix_in,
  input logic [31:0]   pix_out,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          reg_wr,
  input logic [2:0]    reg_idx,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          frame_start,
  input logic          locked,
  input logic [XW-1:0] act_x,
  input logic          in_win,
  input logic          fetch_go
);
  logic [5:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (mem_rd_en) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  p_quiet_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |-> pix_out == pix_in);

  p_right_clip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x >= scr_width) |-> (pix_out == pix_in && !in_win));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> mem_rd_addr == $past(mem_rd_addr) + 1'b1);

  p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> run_q < 6'd16);

  p_burst_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_en) |-> $past(fetch_go));

  p_lock_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 3'd1 || reg_idx == 3'd2) |-> reg_rdata[31] == locked);

  p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 3'd1 && reg_wdata[31]) |=> locked);

  p_frame_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_x) |-> ($past(frame_start) && !$past(locked)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .pix_x(pix_x), .scr_width(scr_width),
  .pix_in(pix_in), .pix_out(pix_out), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .frame_start(frame_start), .locked(locked), .act_x(act_x), .in_win(in_win),
  .fetch_go(fetch_go)
);

// File: tb/cursor_overlay_tb.sv
`timescale 1ns/1ps
module cursor_overlay_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, frame_start = 1'b0, line_start = 1'b0, cur_en = 1'b1;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, pix_in = '0, pix_out;
  logic [11:0] line_y = '0, vdisp = 12'd479;
  logic [13:0] pix_x = '0, scr_width = 14'd640;
  logic        mem_rd_en;
  logic [26:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;

  always #2.5 clk = ~clk;

  cursor_overlay u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .frame_start(frame_start), .line_start(line_start),
    .line_y(line_y), .vdisp(vdisp), .cur_en(cur_en), .pix_x(pix_x), .pix_in(pix_in),
    .scr_width(scr_width), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .pix_out(pix_out)
  );

  logic [7:0]  mem [0:255];
  logic [26:0] rd_log [$];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];
  always @(posedge clk) if (rst_n && mem_rd_en) rd_log.push_back(mem_rd_addr);

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench model of the active cursor state.
  int m_x = 0, m_y = 0, m_org = 0, m_w = 640, m_vd = 479, m_line = 0;
  logic [23:0] m_c0 = '0, m_c1 = '0;
  bit m_en = 1, m_hit = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check32(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_px(int x, logic [31:0] pin);
    int col, row, ab;
    logic a, xr;
    if (!(m_en && m_hit && x >= m_x && x < m_x + 64 && x < m_w)) return pin;
    row = m_line - m_y;
    col = x - m_x;
    ab  = m_org + 16 * row + col / 8;
    a   = mem[ab & 255][7 - col % 8];
    xr  = mem[(ab + 8) & 255][7 - col % 8];
    if (a && xr) return ~pin;
    if (a) return pin;
    return {xr ? m_c1 : m_c0, 8'hFF};
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk); #1;
      if (exp_q.size() > 0) check32(tag_q.pop_front(), pix_out, exp_q.pop_front());
    end
  end

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_idx = 3'(idx); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_check(int idx, logic [31:0] exp, string tag);
    @(negedge clk); reg_idx = 3'(idx); #1;
    check32(tag, reg_rdata, exp);
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic do_line(int line);
    rd_log.delete();
    @(negedge clk); line_start = 1'b1; line_y = 12'(line);
    @(negedge clk); line_start = 1'b0;
    repeat (24) @(negedge clk);
    m_line = line;
    m_hit  = m_en && line >= m_y && line < m_y + 64 && line <= m_vd;
  endtask

  task automatic check_reads(int n, int first, string tag);
    check32(tag, 32'(rd_log.size()), 32'(n));
    for (int i = 0; i < n && i < rd_log.size(); i++)
      check32(tag, 32'(rd_log[i]), 32'((first + i) & 27'h7FFFFFF));
  endtask

  task automatic drive_px(int x, logic [31:0] pin, string tag);
    @(negedge clk); pix_x = 14'(x); pix_in = pin;
    exp_q.push_back(model_px(x, pin));
    tag_q.push_back(tag);
  endtask

  task automatic sweep(int x0, int x1, string tag);
    for (int x = x0; x <= x1; x++) drive_px(x, (32'(x) * 32'h0101_0101) ^ 32'hC3A5_5A3C, tag);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 5; i++) rd_check(i, 32'h0, "R1");
    check32("R1", {31'b0, mem_rd_en}, 32'h0);
    drive_px(5, 32'hDEAD_BEEF, "R1");
    repeat (2) @(negedge clk);

    // R2 masks, R3 lock
    wr(0, 32'hFFFF_FFFF); rd_check(0, 32'h87FF_FFF0, "R2");
    rd_check(1, 32'h8000_0000, "R3");
    wr(1, 32'hFFFF_FFFF); rd_check(1, 32'hBFFF_0FFF, "R2");
    wr(2, 32'h7FFF_FFFF); rd_check(2, 32'h003F_003F, "R2");
    rd_check(1, 32'h3FFF_0FFF, "R3");
    rd_check(0, 32'h07FF_FFF0, "R3");
    wr(3, 32'hFFFF_FFFF); rd_check(3, 32'h00FF_FFFF, "R2");
    wr(4, 32'hAB12_3456); rd_check(4, 32'h0012_3456, "R2");

    wr(0, 32'h60);
    wr(2, 32'h0010_0001);
    wr(1, (32'd100 << 16) | 32'd10);
    wr(3, 32'h0011_2233); m_c0 = 24'h112233;
    wr(4, 32'h00AA_BBCC); m_c1 = 24'hAABBCC;

    // R4 staged values not used before frame start: active X=0, Y=0, origin 0
    do_line(12);
    check_reads(16, 12 * 16, "R4");
    sweep(0, 4, "R4");

    frame(); m_x = 100; m_y = 10; m_org = 32'h40;
    mem[8'h60] = 8'hC0; mem[8'h68] = 8'hA0;
    do_line(12);
    check_reads(16, 32'h60, "R5");
    sweep(100, 103, "R6");
    sweep(95, 170, "R7");

    scr_width = 14'd130; m_w = 130;
    sweep(125, 135, "R9");
    scr_width = 14'd640; m_w = 640;

    do_line(9);  check_reads(0, 0, "R8"); sweep(98, 106, "R8");
    do_line(74); check_reads(0, 0, "R8"); sweep(98, 106, "R8");
    do_line(73); check_reads(16, 32'h40 + 63 * 16, "R5"); sweep(98, 110, "R7");
    vdisp = 12'd11; m_vd = 11;
    do_line(12); check_reads(0, 0, "R8"); sweep(98, 106, "R8");
    vdisp = 12'd479; m_vd = 479;
    do_line(12);
    cur_en = 1'b0; m_en = 0;
    sweep(98, 108, "R8");
    cur_en = 1'b1; m_en = 1;

    // R4 lock holds staged position
    wr(1, 32'h8000_0000 | (32'd200 << 16) | 32'd10);
    rd_check(2, 32'h8010_0001, "R3");
    frame();
    do_line(12); sweep(98, 104, "R4");
    wr(1, (32'd200 << 16) | 32'd10);
    do_line(12); sweep(198, 202, "R4");
    frame(); m_x = 200;
    do_line(12); sweep(98, 102, "R4"); sweep(198, 204, "R4");

    // R5 hotspot change moves fetch origin
    wr(2, 32'h0);
    frame(); m_org = 32'h60;
    do_line(12); check_reads(16, 32'h80, "R5");
    sweep(199, 210, "R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule